// File: doc/BRIEF.md
# Receive Descriptor Writeback Formatter

This block assembles the fields that a receive engine writes back into one advanced descriptor slot once that slot's buffers have been filled. It runs once per slot. The engine supplies five groups of inputs: the byte counts placed in the header buffer and in the packet buffer, the result of the header-split decision, the parsed protocol flags, the receive-side-scaling result, and the checksum-control bits. When the engine pulses the format strobe, the block computes the length, packet-info, header-info, hash/identification and status/error words, and registers them.

The reported length depends on two things: the queue's split mode, and whether the header was split off and whether it overflowed the header buffer. One 32-bit word is shared between the scaling hash and the IPv4 identification, and the checksum-control bits decide which of the two it carries. Metadata that describes the whole packet appears only in the end-of-packet slot. Every slot reports the split fields and the done bit.

Top module: `rxwb_formatter`

## Requirements
- R1: Every writeback sets the done bit, bit 0 of `stat_err`. Every bit of `stat_err` other than bits 0 and 23 is zero.
- R2: When `eop` is low, `pkt_info` and `hash_word` are both zero. Length, header info and the overflow bit are still reported.
- R3: When `split_always` is high, `wb_len` equals `pay_cnt`.
- R4: When `split_always` is low, `wb_len` depends on `split_hdr` and `hdr_ovf`. If the two are equal, `wb_len` is `hdr_cnt + pay_cnt` modulo 2^16. If they differ, `wb_len` is `pay_cnt`.
- R5: `hdr_info` holds `hdr_len` in bits 14:5 and `split_hdr` in bit 15. Bits 4:0 are zero.
- R6: `hdr_ovf` is reported in bit 23 of `stat_err`.
- R7: At end of packet, `pkt_info` is the scaling type (bits 3:0) OR'd with the packet type shifted left by 4. The scaling type is used only when both `csum_pkt_off` and `rss_en` are set; otherwise bits 3:0 are zero.
- R8: Packet type encoding: bit 0 IPv4, bit 2 IPv6, bit 3 IPv6 with extension headers, bit 4 TCP, bit 5 UDP, bit 6 SCTP. IPv6 has priority over IPv4. IPv6 is not reported when `ip6_off` is set; IPv4 is reported instead if present. The transport bits have the priority TCP, then UDP, then SCTP. The SCTP bit is set only when an IP layer is reported.
- R9: At end of packet, `hash_word` carries `rss_hash` when `csum_pkt_off` and `rss_en` are both set. It carries `ip_ident` zero-extended when `csum_pkt_off` is clear, `ip_pay_csum_en` is set and `is_ip4` is set. In every other case it is zero.
- R10: All outputs are registered. `wb_valid` is high for exactly the one cycle after each `fmt_go` cycle. The fields hold their values until the next strobe.
- R11: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_go | input | 1 | Format strobe, one cycle per descriptor slot |
| eop | input | 1 | This slot closes the packet |
| hdr_cnt | input | 16 | Bytes written to the header buffer |
| pay_cnt | input | 16 | Bytes written to the packet buffer |
| split_hdr | input | 1 | Header was split off |
| hdr_ovf | input | 1 | Header length exceeded the header buffer |
| hdr_len | input | 10 | Header length from the split decision |
| split_always | input | 1 | Queue is in always-split mode |
| rss_en | input | 1 | Scaling result is valid |
| rss_hash | input | 32 | Scaling hash |
| rss_kind | input | 4 | Scaling hash type |
| ip_ident | input | 16 | IPv4 identification field |
| is_ip4 | input | 1 | Packet has IPv4 |
| is_ip6 | input | 1 | Packet has IPv6 |
| ip6_ext | input | 1 | IPv6 extension headers present |
| is_tcp | input | 1 | Transport is TCP |
| is_udp | input | 1 | Transport is UDP |
| is_sctp | input | 1 | Transport is SCTP |
| ip6_off | input | 1 | IPv6 recognition disabled |
| csum_pkt_off | input | 1 | Packet checksum reporting disabled |
| ip_pay_csum_en | input | 1 | IP payload checksum enabled |
| wb_valid | output | 1 | Fields valid this cycle |
| pkt_info | output | 16 | Packet-info word |
| hdr_info | output | 16 | Header-info word |
| hash_word | output | 32 | Scaling hash or IP identification |
| stat_err | output | 32 | Status/error word |
| wb_len | output | 16 | Reported length |

## Verification
Two selections resolve in the same strobe at end of packet: the split-dependent length choice and the choice between hash and IP identification in the shared word. Random strobes draw the split flags, the split mode and the three checksum/scaling control bits independently, so every combination of the two selections falls into one cycle many times. Directed cases pin the overflow-with-split length and the hash/identification boundary. Every field of each writeback is compared with a reference computed in the bench from the requirements, and so is the field hold on the following cycle.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;
  localparam int PT_IPV4  = 0;
  localparam int PT_IPV6  = 2;
  localparam int PT_IPV6X = 3;
  localparam int PT_TCP   = 4;
  localparam int PT_UDP   = 5;
  localparam int PT_SCTP  = 6;
  localparam int PTYPE_W  = 7;
  localparam int PTYPE_SH = 4;
  localparam int HLEN_SH  = 5;
  localparam int SPH_BIT  = 15;
  localparam int DONE_BIT = 0;
  localparam int HBO_BIT  = 23;
  localparam int INFO_W   = 16;
  localparam int STAT_W   = 32;

  typedef struct packed {
    logic ip4;
    logic ip6;
    logic ip6_ext;
    logic tcp;
    logic udp;
    logic sctp;
  } proto_t;
endpackage

// File: rtl/rxwb_ptype.sv
module rxwb_ptype
  import rxwb_pkg::*;
(
  input  proto_t               proto,
  input  logic                 ip6_off,
  output logic [PTYPE_W-1:0]   ptype
);
  logic l3_seen;

  always_comb begin
    ptype   = '0;
    l3_seen = 1'b0;
    if (proto.ip6 && !ip6_off) begin
      l3_seen = 1'b1;
      if (proto.ip6_ext) ptype[PT_IPV6X] = 1'b1;
      else               ptype[PT_IPV6]  = 1'b1;
    end else if (proto.ip4) begin
      l3_seen = 1'b1;
      ptype[PT_IPV4] = 1'b1;
    end
    if (proto.tcp)                 ptype[PT_TCP]  = 1'b1;
    else if (proto.udp)            ptype[PT_UDP]  = 1'b1;
    else if (proto.sctp && l3_seen) ptype[PT_SCTP] = 1'b1;
  end
endmodule

// File: rtl/rxwb_len_sel.sv
module rxwb_len_sel #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] hdr_cnt,
  input  logic [CNT_W-1:0] pay_cnt,
  input  logic             split_hdr,
  input  logic             hdr_ovf,
  input  logic             split_always,
  output logic [CNT_W-1:0] len
);
  logic [CNT_W-1:0] both_sum;

  assign both_sum = hdr_cnt + pay_cnt;

  always_comb begin
    if (split_always)            len = pay_cnt;
    else if (split_hdr == hdr_ovf) len = both_sum;
    else                         len = pay_cnt;
  end
endmodule

// File: rtl/rxwb_meta_sel.sv
module rxwb_meta_sel
  import rxwb_pkg::*;
#(
  parameter int HASH_W = 32,
  parameter int RSST_W = 4,
  parameter int ID_W   = 16
) (
  input  logic               eop,
  input  logic               csum_pkt_off,
  input  logic               ip_pay_csum_en,
  input  logic               rss_en,
  input  logic [HASH_W-1:0]  rss_hash,
  input  logic [RSST_W-1:0]  rss_kind,
  input  logic [ID_W-1:0]    ip_ident,
  input  logic               is_ip4,
  input  logic [PTYPE_W-1:0] ptype,
  output logic [INFO_W-1:0]  pkt_info,
  output logic [HASH_W-1:0]  hash_word
);
  logic use_hash;
  logic use_ident;

  assign use_hash  = csum_pkt_off && rss_en;
  assign use_ident = !csum_pkt_off && ip_pay_csum_en && is_ip4;

  always_comb begin
    pkt_info  = '0;
    hash_word = '0;
    if (eop) begin
      if (use_hash) begin
        pkt_info[RSST_W-1:0] = rss_kind;
        hash_word            = rss_hash;
      end else if (use_ident) begin
        hash_word = HASH_W'(ip_ident);
      end
      pkt_info = pkt_info | (INFO_W'(ptype) << PTYPE_SH);
    end
  end
endmodule

// File: rtl/rxwb_formatter.sv
module rxwb_formatter
  import rxwb_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int HLEN_W = 10,
  parameter int HASH_W = 32,
  parameter int RSST_W = 4,
  parameter int ID_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fmt_go,
  input  logic              eop,
  input  logic [CNT_W-1:0]  hdr_cnt,
  input  logic [CNT_W-1:0]  pay_cnt,
  input  logic              split_hdr,
  input  logic              hdr_ovf,
  input  logic [HLEN_W-1:0] hdr_len,
  input  logic              split_always,
  input  logic              rss_en,
  input  logic [HASH_W-1:0] rss_hash,
  input  logic [RSST_W-1:0] rss_kind,
  input  logic [ID_W-1:0]   ip_ident,
  input  logic              is_ip4,
  input  logic              is_ip6,
  input  logic              ip6_ext,
  input  logic              is_tcp,
  input  logic              is_udp,
  input  logic              is_sctp,
  input  logic              ip6_off,
  input  logic              csum_pkt_off,
  input  logic              ip_pay_csum_en,
  output logic              wb_valid,
  output logic [INFO_W-1:0] pkt_info,
  output logic [INFO_W-1:0] hdr_info,
  output logic [HASH_W-1:0] hash_word,
  output logic [STAT_W-1:0] stat_err,
  output logic [CNT_W-1:0]  wb_len
);
  localparam logic [STAT_W-1:0] STAT_USED = (STAT_W'(1) << DONE_BIT) | (STAT_W'(1) << HBO_BIT);

  proto_t               proto;
  logic [PTYPE_W-1:0]   ptype_c;
  logic [CNT_W-1:0]     len_c;
  logic [INFO_W-1:0]    pinfo_c;
  logic [HASH_W-1:0]    hash_c;
  logic [INFO_W-1:0]    hinfo_c;
  logic [STAT_W-1:0]    stat_c;

  assign proto = '{ip4: is_ip4, ip6: is_ip6, ip6_ext: ip6_ext,
                   tcp: is_tcp, udp: is_udp, sctp: is_sctp};

  rxwb_ptype u_ptype (
    .proto   (proto),
    .ip6_off (ip6_off),
    .ptype   (ptype_c)
  );

  rxwb_len_sel #(.CNT_W(CNT_W)) u_len (
    .hdr_cnt      (hdr_cnt),
    .pay_cnt      (pay_cnt),
    .split_hdr    (split_hdr),
    .hdr_ovf      (hdr_ovf),
    .split_always (split_always),
    .len          (len_c)
  );

  rxwb_meta_sel #(.HASH_W(HASH_W), .RSST_W(RSST_W), .ID_W(ID_W)) u_meta (
    .eop            (eop),
    .csum_pkt_off   (csum_pkt_off),
    .ip_pay_csum_en (ip_pay_csum_en),
    .rss_en         (rss_en),
    .rss_hash       (rss_hash),
    .rss_kind       (rss_kind),
    .ip_ident       (ip_ident),
    .is_ip4         (is_ip4),
    .ptype          (ptype_c),
    .pkt_info       (pinfo_c),
    .hash_word      (hash_c)
  );

  // Split fields are cleared then filled for every slot.
  always_comb begin
    hinfo_c = '0;
    hinfo_c[HLEN_SH +: HLEN_W] = hdr_len;
    hinfo_c[SPH_BIT] = split_hdr;
    stat_c = '0;
    stat_c[DONE_BIT] = 1'b1;
    stat_c[HBO_BIT]  = hdr_ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid  <= 1'b0;
      pkt_info  <= '0;
      hdr_info  <= '0;
      hash_word <= '0;
      stat_err  <= '0;
      wb_len    <= '0;
    end else begin
      wb_valid <= fmt_go;
      if (fmt_go) begin
        pkt_info  <= pinfo_c;
        hdr_info  <= hinfo_c;
        hash_word <= hash_c;
        stat_err  <= stat_c;
        wb_len    <= len_c;
      end
    end
  end

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    fmt_go |=> wb_valid);
  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    !fmt_go |=> !wb_valid);
  a_r1_status_bits: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (stat_err[DONE_BIT] && ((stat_err & ~STAT_USED) == '0)));
  a_r2_quiet_mid_packet: assert property (@(posedge clk) disable iff (rst)
    (fmt_go && !eop) |=> (pkt_info == '0 && hash_word == '0));
  a_r3_split_always_len: assert property (@(posedge clk) disable iff (rst)
    (fmt_go && split_always) |=> (wb_len == $past(pay_cnt)));
  a_r9_hash_carried: assert property (@(posedge clk) disable iff (rst)
    (fmt_go && eop && csum_pkt_off && rss_en) |=> (hash_word == $past(rss_hash)));
  a_r6_overflow_bit: assert property (@(posedge clk) disable iff (rst)
    fmt_go |=> (stat_err[HBO_BIT] == $past(hdr_ovf)));
endmodule

// File: tb/test_rxwb_formatter.sv
`timescale 1ns/1ps
module test_rxwb_formatter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fmt_go = 1'b0;
  logic eop, split_hdr, hdr_ovf, split_always, rss_en;
  logic [15:0] hdr_cnt, pay_cnt, ip_ident;
  logic [9:0]  hdr_len;
  logic [31:0] rss_hash;
  logic [3:0]  rss_kind;
  logic is_ip4, is_ip6, ip6_ext, is_tcp, is_udp, is_sctp;
  logic ip6_off, csum_pkt_off, ip_pay_csum_en;
  logic        wb_valid;
  logic [15:0] pkt_info, hdr_info, wb_len;
  logic [31:0] hash_word, stat_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rxwb_formatter i_rxwb_formatter (
    .clk(clk), .rst(rst), .fmt_go(fmt_go), .eop(eop),
    .hdr_cnt(hdr_cnt), .pay_cnt(pay_cnt), .split_hdr(split_hdr), .hdr_ovf(hdr_ovf),
    .hdr_len(hdr_len), .split_always(split_always), .rss_en(rss_en),
    .rss_hash(rss_hash), .rss_kind(rss_kind), .ip_ident(ip_ident),
    .is_ip4(is_ip4), .is_ip6(is_ip6), .ip6_ext(ip6_ext), .is_tcp(is_tcp),
    .is_udp(is_udp), .is_sctp(is_sctp), .ip6_off(ip6_off),
    .csum_pkt_off(csum_pkt_off), .ip_pay_csum_en(ip_pay_csum_en),
    .wb_valid(wb_valid), .pkt_info(pkt_info), .hdr_info(hdr_info),
    .hash_word(hash_word), .stat_err(stat_err), .wb_len(wb_len)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] ref_len();
    if (split_always) return pay_cnt;
    if (split_hdr == hdr_ovf) return 16'(hdr_cnt + pay_cnt);
    return pay_cnt;
  endfunction

  function automatic logic [6:0] ref_ptype();
    logic [6:0] p = '0;
    logic l3 = 1'b0;
    if (is_ip6 && !ip6_off) begin l3 = 1; if (ip6_ext) p[3] = 1; else p[2] = 1; end
    else if (is_ip4) begin l3 = 1; p[0] = 1; end
    if (is_tcp) p[4] = 1;
    else if (is_udp) p[5] = 1;
    else if (is_sctp && l3) p[6] = 1;
    return p;
  endfunction

  function automatic logic [15:0] ref_pinfo();
    logic [15:0] v;
    if (!eop) return 16'h0;
    v = (csum_pkt_off && rss_en) ? {12'h0, rss_kind} : 16'h0;
    return v | ({9'h0, ref_ptype()} << 4);
  endfunction

  function automatic logic [31:0] ref_hash();
    if (!eop) return 32'h0;
    if (csum_pkt_off && rss_en) return rss_hash;
    if (!csum_pkt_off && ip_pay_csum_en && is_ip4) return {16'h0, ip_ident};
    return 32'h0;
  endfunction

  task automatic clear_in();
    eop = 1; hdr_cnt = 0; pay_cnt = 0; split_hdr = 0; hdr_ovf = 0; hdr_len = 0;
    split_always = 0; rss_en = 0; rss_hash = 0; rss_kind = 0; ip_ident = 0;
    is_ip4 = 0; is_ip6 = 0; ip6_ext = 0; is_tcp = 0; is_udp = 0; is_sctp = 0;
    ip6_off = 0; csum_pkt_off = 0; ip_pay_csum_en = 0;
  endtask

  task automatic rand_in();
    eop = 1'($urandom); hdr_cnt = 16'($urandom); pay_cnt = 16'($urandom);
    split_hdr = 1'($urandom); hdr_ovf = 1'($urandom); hdr_len = 10'($urandom);
    split_always = 1'($urandom); rss_en = 1'($urandom); rss_hash = $urandom;
    rss_kind = 4'($urandom); ip_ident = 16'($urandom);
    is_ip4 = 1'($urandom); is_ip6 = 1'($urandom); ip6_ext = 1'($urandom);
    is_tcp = 1'($urandom); is_udp = 1'($urandom); is_sctp = 1'($urandom);
    ip6_off = 1'($urandom); csum_pkt_off = 1'($urandom); ip_pay_csum_en = 1'($urandom);
  endtask

  // Inputs already set; strobe one cycle, check at the following negedge.
  task automatic strobe_check();
    logic [15:0] e_len, e_pinfo, e_hinfo;
    logic [31:0] e_hash, e_stat;
    e_len   = ref_len();
    e_pinfo = ref_pinfo();
    e_hash  = ref_hash();
    e_hinfo = {split_hdr, 5'b0, hdr_len, 5'b0} & 16'hFFE0 | {split_hdr, 15'h0};
    e_hinfo = {split_hdr, hdr_len, 5'b0};
    e_stat  = 32'h1 | ({31'h0, hdr_ovf} << 23);
    fmt_go = 1'b1;
    @(negedge clk);
    fmt_go = 1'b0;
    chk("R10 valid after strobe", {31'h0, wb_valid}, 32'h1);
    chk("R1/R6 status word", stat_err, e_stat);
    chk(split_always ? "R3 length split-always" : "R4 length", {16'h0, wb_len}, {16'h0, e_len});
    chk("R5 header info", {16'h0, hdr_info}, {16'h0, e_hinfo});
    chk(eop ? "R7/R8 packet info" : "R2 packet info mid-packet", {16'h0, pkt_info}, {16'h0, e_pinfo});
    chk(eop ? "R9 hash word" : "R2 hash word mid-packet", hash_word, e_hash);
    rand_in();
    @(negedge clk);
    chk("R10 valid single cycle", {31'h0, wb_valid}, 32'h0);
    chk("R10 length held", {16'h0, wb_len}, {16'h0, e_len});
    chk("R10 hash held", hash_word, e_hash);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    clear_in();
    repeat (3) @(negedge clk);
    chk("R11 reset valid", {31'h0, wb_valid}, 0);
    chk("R11 reset status", stat_err, 0);
    chk("R11 reset length", {16'h0, wb_len}, 0);
    chk("R11 reset hash", hash_word, 0);
    chk("R11 reset pinfo", {16'h0, pkt_info}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R3: split-always reports only packet count
    clear_in(); split_always = 1; split_hdr = 1; hdr_cnt = 40; pay_cnt = 300; hdr_len = 40;
    strobe_check();
    // R4: split with no overflow -> packet count only
    clear_in(); split_hdr = 1; hdr_cnt = 54; pay_cnt = 1000; hdr_len = 54;
    strobe_check();
    // R4: split and overflow equal -> sum; R6 overflow bit
    clear_in(); split_hdr = 1; hdr_ovf = 1; hdr_cnt = 0; pay_cnt = 1500; hdr_len = 10'h3FF;
    strobe_check();
    // R4: neither -> sum with wrap
    clear_in(); hdr_cnt = 16'hFFF0; pay_cnt = 16'h0020;
    strobe_check();
    // R9 hash selected; R7 rss type in low bits; R8 IPv6 ext + TCP
    clear_in(); csum_pkt_off = 1; rss_en = 1; rss_hash = 32'hDEADBEEF; rss_kind = 4'h9;
    is_ip6 = 1; ip6_ext = 1; is_tcp = 1; is_ip4 = 1; ip_pay_csum_en = 1;
    strobe_check();
    // R9 identification selected; R8 IPv6 disabled falls back to IPv4 + UDP
    clear_in(); ip_pay_csum_en = 1; is_ip4 = 1; is_ip6 = 1; ip6_off = 1; is_udp = 1;
    ip_ident = 16'hA55A; rss_en = 1; rss_hash = 32'h12345678;
    strobe_check();
    // R9 neither: checksum off but scaling disabled
    clear_in(); csum_pkt_off = 1; ip_pay_csum_en = 1; is_ip4 = 1; ip_ident = 16'h1111;
    strobe_check();
    // R8 SCTP needs an IP layer
    clear_in(); is_sctp = 1;
    strobe_check();
    clear_in(); is_sctp = 1; is_ip6 = 1;
    strobe_check();
    // R2 mid-packet slot with all metadata present
    clear_in(); eop = 0; csum_pkt_off = 1; rss_en = 1; rss_hash = 32'hFFFF0000;
    is_ip4 = 1; is_tcp = 1; split_hdr = 1; hdr_len = 20; hdr_cnt = 20; pay_cnt = 64;
    strobe_check();

    for (int n = 0; n < 300; n++) begin
      rand_in();
      strobe_check();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule